// File: doc/BRIEF.md
# Host Packet Bridge with Shared Byte Port

This block sits between an external MAC and a packet modem and is the device side of that link. The host and the device share one 8-bit data port. On the transmit side the host opens a session by raising `tx_en` and sends bytes with an active-low write strobe. The bridge stores those bytes and sends them to the modulator over a ready/valid stream. A byte is tagged as the end of a packet when the session closes. Forwarding does not wait for the session to end, because the host writes faster than the modulator reads.

On the receive side the demodulator pushes whole frames into a second buffer. After a frame is complete, the bridge raises `rx_dv`. The host then reads the frame one byte at a time with an active-low read strobe. A strobe acts on its rising edge, sampled with the reference clock, and only while chip select is low. The data pins are three-state, modelled here as `dat_i`, `dat_o` and `dat_oe`. Receive has priority over transmit. `crs` tells the host when the bridge can take another complete packet. A frame that fails or overflows is thrown away and flagged on `rx_er`.

Top module: `host_pkt_bridge`

## Requirements
- R1: While reset is asserted, and after it is released, `crs`, `rx_dv`, `rx_er`, `dat_oe` and `mod_valid` are all low.
- R2: A rising edge of `wr_n` with `cs_n` low and `tx_en` high captures `dat_i`. Captured bytes reach `mod_data` in order. `mod_last`=1 marks only the last byte written before `tx_en` falls, and a held beat stays stable while `mod_ready` is low.
- R3: Once two bytes of a session have been written, `mod_valid` is high while `tx_en` is still high.
- R4: `crs` is high on the cycle after `tx_en` is sampled high. After `tx_en` falls, `crs` stays high until the final byte has been stored and the transmit buffer has at least `PKT_MAX` free bytes. Then it falls.
- R5: A write or read strobe edge sampled while `cs_n` is high has no effect.
- R6: `rx_dv` rises once a whole frame is stored. `dat_o` shows the frame bytes in arrival order, and each rising edge of `rd_n` moves to the next byte. `rx_dv` falls on the cycle after the strobe that reads the final byte.
- R7: `rx_dv` never rises while `tx_en` is high. While `rx_dv` is high, write strobes are ignored.
- R8: `dat_oe` is high exactly when `rx_dv` is high and `cs_n` is low.
- R9: A frame that has `dem_err` on any byte, or that overflows the receive buffer, is discarded whole. `rx_er` pulses for one cycle after its last byte, `rx_dv` stays low, and the space is freed for later frames.
- R10: A frame of exactly `RX_DEPTH` bytes fits into an empty receive buffer and reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low, acts on rising edge |
| rd_n | input | 1 | Read strobe, active low, acts on rising edge |
| tx_en | input | 1 | Host transmit session open |
| dat_i | input | 8 | Data port, host to bridge |
| dat_o | output | 8 | Data port, bridge to host |
| dat_oe | output | 1 | Drive enable for the data port |
| crs | output | 1 | Transmit busy / carrier sense |
| rx_dv | output | 1 | Received frame ready for reading |
| rx_er | output | 1 | One-cycle pulse on a dropped frame |
| mod_data | output | 8 | Byte to modulator |
| mod_last | output | 1 | Final byte of packet |
| mod_valid | output | 1 | Modulator beat valid |
| mod_ready | input | 1 | Modulator accepts beat |
| dem_data | input | 8 | Byte from demodulator |
| dem_last | input | 1 | Final byte of received frame |
| dem_err | input | 1 | Byte belongs to a failed frame |
| dem_valid | input | 1 | Demodulator beat valid |

## Verification
The bench builds the bridge with both buffers 16 bytes deep and `PKT_MAX` set to 8. With these values a 16-byte packet fills the transmit side completely, and a 12-byte packet leaves less than `PKT_MAX` free, so the late fall of `crs` can be seen. A 16-byte receive frame is the exact-fit boundary. A 20-byte frame overflows, so its drop and the recovery of the space can be checked in a few hundred cycles.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              last;
    logic [BYTE_W-1:0] dat;
  } pbb_beat_t;

  localparam int BEAT_W = $bits(pbb_beat_t);
endpackage

// File: rtl/pbb_strobe.sv
module pbb_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_n,
  input  logic cs_n,
  output logic rise
);
  logic strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b1;
    else        strb_q <= strb_n;
  end

  assign rise = strb_n & ~strb_q & ~cs_n;
endmodule

// File: rtl/pbb_fifo.sv
module pbb_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  input  logic                       commit,
  input  logic                       rewind,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wptr_q, rptr_q, cptr_q;
  logic [CW-1:0] wptr_d, rptr_d, cptr_d;
  logic          push_ok, pop_ok;

  assign count   = wptr_q - rptr_q;
  assign push_ok = push & (count != FULL_CNT) & ~rewind;
  assign pop_ok  = pop & (count != '0);
  assign dout    = mem[rptr_q[AW-1:0]];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cptr_d = cptr_q;
    if (rewind)       wptr_d = cptr_q;
    else if (push_ok) wptr_d = wptr_q + 1'b1;
    if (pop_ok)       rptr_d = rptr_q + 1'b1;
    if (commit)       cptr_d = wptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cptr_q <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cptr_q <= cptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q[AW-1:0]] <= din;
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
endmodule

// File: rtl/pbb_tx.sv
module pbb_tx
  import pbb_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int PKT_MAX = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              wr_ok,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              mod_ready,
  output logic              crs,
  output logic              mod_valid,
  output logic [BYTE_W-1:0] mod_data,
  output logic              mod_last
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] NEED = CW'(PKT_MAX);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic              hold_v_q, hold_v_d;
  logic [BYTE_W-1:0] hold_d_q, hold_d_d;
  logic              tx_en_q, crs_q, crs_d;
  logic              end_evt, take, push;
  logic [CW-1:0]     count, free;
  pbb_beat_t         in_beat, out_beat;
  logic [BEAT_W-1:0] out_raw;

  assign end_evt = tx_en_q & ~tx_en;
  assign take    = wr_ok & tx_en;
  assign push    = hold_v_q & (take | end_evt) & (count != CAP);
  assign free    = CAP - count;
  assign in_beat = '{last: end_evt, dat: hold_d_q};

  always_comb begin
    hold_v_d = hold_v_q;
    hold_d_d = hold_d_q;
    if (take) begin
      hold_v_d = 1'b1;
      hold_d_d = wr_data;
    end else if (end_evt) begin
      hold_v_d = 1'b0;
    end
    crs_d = tx_en | (crs_q & (hold_v_q | (free < NEED)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q <= 1'b0;
      hold_d_q <= '0;
      tx_en_q  <= 1'b0;
      crs_q    <= 1'b0;
    end else begin
      hold_v_q <= hold_v_d;
      hold_d_q <= hold_d_d;
      tx_en_q  <= tx_en;
      crs_q    <= crs_d;
    end
  end

  pbb_fifo #(.W(BEAT_W), .DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .din    (in_beat),
    .pop    (mod_valid & mod_ready),
    .commit (1'b0),
    .rewind (1'b0),
    .dout   (out_raw),
    .count  (count)
  );

  assign out_beat  = out_raw;
  assign mod_valid = (count != '0);
  assign mod_data  = out_beat.dat;
  assign mod_last  = out_beat.last;
  assign crs       = crs_q;

  p_crs_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |=> crs);
  p_crs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (crs && !tx_en && hold_v_q) |=> crs);
  p_beat_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_valid && !mod_ready) |=> (mod_valid && $stable(mod_data) && $stable(mod_last)));
endmodule

// File: rtl/pbb_rx.sv
module pbb_rx
  import pbb_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dem_valid,
  input  logic [BYTE_W-1:0] dem_data,
  input  logic              dem_last,
  input  logic              dem_err,
  input  logic              tx_en,
  input  logic              rd_ok,
  output logic              rx_dv,
  output logic              rx_er,
  output logic [BYTE_W-1:0] rx_data
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic          drop_q, drop_d;
  logic          dv_q, dv_d;
  logic          er_q;
  logic [CW-1:0] frames_q, frames_d;
  logic [CW-1:0] count;
  logic          full, bad, wr, commit, rewind, pop, last_pop;
  pbb_beat_t     in_beat, head;
  logic [BEAT_W-1:0] head_raw;

  assign full     = (count == CAP);
  assign bad      = drop_q | full | dem_err;
  assign wr       = dem_valid & ~bad;
  assign commit   = wr & dem_last;
  assign rewind   = dem_valid & bad & dem_last;
  assign pop      = dv_q & rd_ok;
  assign head     = head_raw;
  assign last_pop = pop & head.last;
  assign in_beat  = '{last: dem_last, dat: dem_data};

  always_comb begin
    drop_d   = drop_q;
    if (dem_valid && bad) drop_d = ~dem_last;
    frames_d = frames_q + CW'(commit) - CW'(last_pop);
    if (dv_q) dv_d = ~last_pop;
    else      dv_d = (frames_q != '0) & (count != '0) & ~tx_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_q   <= 1'b0;
      dv_q     <= 1'b0;
      er_q     <= 1'b0;
      frames_q <= '0;
    end else begin
      drop_q   <= drop_d;
      dv_q     <= dv_d;
      er_q     <= rewind;
      frames_q <= frames_d;
    end
  end

  pbb_fifo #(.W(BEAT_W), .DEPTH(DEPTH)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (wr),
    .din    (in_beat),
    .pop    (pop),
    .commit (commit),
    .rewind (rewind),
    .dout   (head_raw),
    .count  (count)
  );

  assign rx_dv   = dv_q;
  assign rx_er   = er_q;
  assign rx_data = head.dat;

  p_dv_no_tx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> !$past(tx_en));
  p_dv_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dv && !rd_ok) |=> rx_dv);
  p_er_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_er |-> $past(dem_valid && dem_last));
endmodule

// File: rtl/host_pkt_bridge.sv
module host_pkt_bridge
  import pbb_pkg::*;
#(
  parameter int TX_DEPTH = 2048,
  parameter int RX_DEPTH = 2048,
  parameter int PKT_MAX  = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              tx_en,
  input  logic [BYTE_W-1:0] dat_i,
  output logic [BYTE_W-1:0] dat_o,
  output logic              dat_oe,
  output logic              crs,
  output logic              rx_dv,
  output logic              rx_er,
  output logic [BYTE_W-1:0] mod_data,
  output logic              mod_last,
  output logic              mod_valid,
  input  logic              mod_ready,
  input  logic [BYTE_W-1:0] dem_data,
  input  logic              dem_last,
  input  logic              dem_err,
  input  logic              dem_valid
);
  localparam int N_STRB = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_i;
  logic [N_STRB-1:0] strb_n, strb_rise;
  logic              wr_ok, rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign strb_n = {rd_n, wr_n};

  for (genvar g = 0; g < N_STRB; g++) begin : g_strb
    pbb_strobe u_strb (
      .clk    (clk),
      .rst_n  (rst_i),
      .strb_n (strb_n[g]),
      .cs_n   (cs_n),
      .rise   (strb_rise[g])
    );
  end

  assign wr_ok = strb_rise[0] & ~rx_dv;
  assign rd_ok = strb_rise[1];

  pbb_tx #(.DEPTH(TX_DEPTH), .PKT_MAX(PKT_MAX)) u_tx (
    .clk       (clk),
    .rst_n     (rst_i),
    .tx_en     (tx_en),
    .wr_ok     (wr_ok),
    .wr_data   (dat_i),
    .mod_ready (mod_ready),
    .crs       (crs),
    .mod_valid (mod_valid),
    .mod_data  (mod_data),
    .mod_last  (mod_last)
  );

  pbb_rx #(.DEPTH(RX_DEPTH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_i),
    .dem_valid (dem_valid),
    .dem_data  (dem_data),
    .dem_last  (dem_last),
    .dem_err   (dem_err),
    .tx_en     (tx_en),
    .rd_ok     (rd_ok),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .rx_data   (dat_o)
  );

  assign dat_oe = rx_dv & ~cs_n;
endmodule

// File: tb/sim_host_pkt_bridge.sv
module sim_host_pkt_bridge;
  localparam int TXD = 16;
  localparam int RXD = 16;
  localparam int PKM = 8;

  logic       clk, rst_n, cs_n, wr_n, rd_n, tx_en, mod_ready;
  logic [7:0] dat_i, dem_data;
  logic       dem_last, dem_err, dem_valid;
  logic [7:0] dat_o, mod_data;
  logic       dat_oe, crs, rx_dv, rx_er, mod_last, mod_valid;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // {dir(1=rx), err, len[5:0], base[7:0]}
  localparam logic [15:0] VEC [8] = '{
    {1'b0, 1'b0, 6'd5,  8'h10},
    {1'b1, 1'b0, 6'd4,  8'h20},
    {1'b0, 1'b0, 6'd1,  8'h30},
    {1'b1, 1'b0, 6'd1,  8'h40},
    {1'b1, 1'b1, 6'd6,  8'h50},
    {1'b0, 1'b0, 6'd16, 8'h60},
    {1'b1, 1'b0, 6'd16, 8'h80},
    {1'b0, 1'b0, 6'd3,  8'hA0}
  };

  host_pkt_bridge #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .PKT_MAX(PKM)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .tx_en(tx_en), .dat_i(dat_i), .dat_o(dat_o), .dat_oe(dat_oe),
    .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .mod_data(mod_data),
    .mod_last(mod_last), .mod_valid(mod_valid), .mod_ready(mod_ready),
    .dem_data(dem_data), .dem_last(dem_last), .dem_err(dem_err),
    .dem_valid(dem_valid)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=%0d exp=<100000", cyc);
        finish_run();
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b);
    dat_i = b;
    wr_n  = 1'b0;
    tick();
    wr_n  = 1'b1;
    tick();
  endtask

  task automatic tx_pkt(input logic [7:0] base, input int len);
    tx_en = 1'b1;
    tick();
    for (int i = 0; i < len; i++) wr_byte(base + 8'(i));
    tx_en = 1'b0;
    tick();
  endtask

  task automatic drain(input string req, input logic [7:0] base, input int len);
    mod_ready = 1'b1;
    for (int i = 0; i < len; i++) begin
      int w = 0;
      while (!mod_valid && w < 50) begin tick(); w++; end
      chk(req, {31'd0, mod_valid}, 32'd1);
      chk(req, {24'd0, mod_data}, {24'd0, base + 8'(i)});
      chk(req, {31'd0, mod_last}, {31'd0, (i == len - 1)});
      tick();
    end
    mod_ready = 1'b0;
  endtask

  task automatic rx_feed(input logic [7:0] base, input int len, input logic err);
    for (int i = 0; i < len; i++) begin
      dem_valid = 1'b1;
      dem_data  = base + 8'(i);
      dem_last  = (i == len - 1);
      dem_err   = err && (i == len - 1);
      tick();
    end
    dem_valid = 1'b0;
    dem_last  = 1'b0;
    dem_err   = 1'b0;
  endtask

  task automatic rx_read(input string req, input logic [7:0] base, input int len);
    int w = 0;
    while (!rx_dv && w < 50) begin tick(); w++; end
    for (int i = 0; i < len; i++) begin
      rd_n = 1'b0;
      tick();
      chk(req, {31'd0, rx_dv}, 32'd1);
      chk("R8", {31'd0, dat_oe}, 32'd1);
      chk(req, {24'd0, dat_o}, {24'd0, base + 8'(i)});
      rd_n = 1'b1;
      tick();
    end
    chk(req, {31'd0, rx_dv}, 32'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; tx_en = 1'b0;
    mod_ready = 1'b0; dat_i = '0; dem_data = '0; dem_last = 1'b0;
    dem_err = 1'b0; dem_valid = 1'b0;
    idle(3);
    // R1: held in reset
    chk("R1", {27'd0, crs, rx_dv, rx_er, dat_oe, mod_valid}, 32'd0);
    rst_n = 1'b1;
    idle(4);
    chk("R1", {27'd0, crs, rx_dv, rx_er, dat_oe, mod_valid}, 32'd0);

    // table-driven packets in both directions
    for (int v = 0; v < 8; v++) begin
      logic       dir, err;
      int         len;
      logic [7:0] base;
      dir  = VEC[v][15];
      err  = VEC[v][14];
      len  = int'(VEC[v][13:8]);
      base = VEC[v][7:0];
      if (!dir) begin
        tx_pkt(base, len);
        drain("R2", base, len);
        idle(3);
        chk("R4", {31'd0, crs}, 32'd0);
      end else if (err) begin
        rx_feed(base, len, 1'b1);
        chk("R9", {31'd0, rx_er}, 32'd1);
        tick();
        chk("R9", {31'd0, rx_er}, 32'd0);
        idle(3);
        chk("R9", {31'd0, rx_dv}, 32'd0);
      end else begin
        rx_feed(base, len, 1'b0);
        rx_read((len == RXD) ? "R10" : "R6", base, len);
      end
    end

    // R4 and R3: crs timing and early forwarding
    tx_en = 1'b1;
    chk("R4", {31'd0, crs}, 32'd0);
    tick();
    chk("R4", {31'd0, crs}, 32'd1);
    wr_byte(8'h01);
    wr_byte(8'h02);
    chk("R3", {31'd0, mod_valid}, 32'd1);
    for (int i = 3; i <= 12; i++) wr_byte(8'(i));
    tx_en = 1'b0;
    tick();
    idle(4);
    chk("R4", {31'd0, crs}, 32'd1);
    drain("R2", 8'h01, 12);
    idle(2);
    chk("R4", {31'd0, crs}, 32'd0);

    // R5: strobes with chip select high
    tx_en = 1'b1;
    tick();
    cs_n = 1'b1;
    wr_byte(8'hE1);
    wr_byte(8'hE2);
    cs_n = 1'b0;
    wr_byte(8'h04);
    wr_byte(8'h05);
    tx_en = 1'b0;
    tick();
    drain("R5", 8'h04, 2);
    idle(3);
    rx_feed(8'h70, 2, 1'b0);
    idle(3);
    cs_n = 1'b1;
    tick();
    chk("R8", {31'd0, dat_oe}, 32'd0);
    rd_n = 1'b0; tick(); rd_n = 1'b1; tick();
    cs_n = 1'b0;
    tick();
    chk("R5", {24'd0, dat_o}, 32'h70);
    rx_read("R5", 8'h70, 2);

    // R7: receive priority over transmit
    tx_en = 1'b1;
    tick();
    rx_feed(8'h90, 2, 1'b0);
    idle(3);
    chk("R7", {31'd0, rx_dv}, 32'd0);
    tx_en = 1'b0;
    idle(3);
    chk("R7", {31'd0, rx_dv}, 32'd1);
    tx_en = 1'b1;
    tick();
    wr_byte(8'h55);
    chk("R7", {31'd0, rx_dv}, 32'd1);
    rx_read("R7", 8'h90, 2);
    wr_byte(8'h66);
    wr_byte(8'h67);
    tx_en = 1'b0;
    tick();
    drain("R7", 8'h66, 2);
    idle(3);

    // R9 and R10: overflow drop then exact fit
    rx_feed(8'hB0, 20, 1'b0);
    chk("R9", {31'd0, rx_er}, 32'd1);
    tick();
    chk("R9", {31'd0, rx_er}, 32'd0);
    idle(3);
    chk("R9", {31'd0, rx_dv}, 32'd0);
    rx_feed(8'hC0, 16, 1'b0);
    rx_read("R10", 8'hC0, 16);
    idle(2);
    chk("R1", {31'd0, mod_valid}, 32'd0);

    finish_run();
  end
endmodule